// File: doc/BRIEF.md
# Scan-Timed Display Interrupt Generator

This block turns the scan timing of a display controller into one pulsed interrupt request. It watches three strobes: a vertical sync pulse, a line-load strobe, and a strobe from the pixel fetch engine that marks the start of each line's video-memory read. The request is tied to that fetch start, not to a sync edge. The fetch engine holds bus priority, so the processor sees the request as soon as the fetch has finished.

A mode bit selects the rate. In per-line mode one request fires for every line-load period, at the fetch that comes before the load. In per-frame mode one request fires for every vertical sync period, at the fetch that comes before the first load after sync. A small configuration register holds the mode bit, the two data-bus polarity controls and a run bit. The mode bit is locked while the block runs. Software must stop the block before it changes the mode.

Top module: `lcd_irq_gen`

## Requirements
- R1: After reset every configuration bit reads 0: per-line mode, run off, bus inversion off, auto-inversion off. `irq_o` is low.
- R2: The configuration word is laid out as bit 0 = per-frame mode, bit 1 = bus inversion, bit 2 = auto-inversion enable, bit 3 = run. A write takes effect at the clock edge where `cfg_we` is sampled high, and `cfg_rdata` shows the stored word.
- R3: In per-line mode (bit 0 = 0), while running, a fetch strobe fires a request if no request has fired since the last line-load strobe or since the block started. Further fetch strobes before the next load fire nothing.
- R4: In per-frame mode (bit 0 = 1), while running, the first fetch strobe after a vertical sync fires a request. Later fetch strobes in the same frame fire nothing.
- R5: A request is a single-cycle high pulse on `irq_o`. It appears in the cycle after the clock edge that samples the fetch strobe.
- R6: While the run bit is 0 no request fires. Clearing the run bit discards a pending first-line condition, so a fetch after a restart without a new vertical sync fires nothing in per-frame mode.
- R7: A write while the run bit is 1 leaves the mode bit at its old value and still updates the other fields. A write while stopped updates the mode bit.
- R8: `bus_inv_o` and `auto_inv_o` follow bits 1 and 2 of the stored word. They can be written whether the block is running or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| vsync_i | input | 1 | Vertical sync pulse, one cycle |
| load_i | input | 1 | Line-load strobe, one cycle |
| fetch_start_i | input | 1 | Start of the line's video-memory fetch, one cycle |
| irq_o | output | 1 | Interrupt request pulse |
| bus_inv_o | output | 1 | Data-bus inversion control |
| auto_inv_o | output | 1 | Auto-inversion enable |
| cfg_rdata | output | CFG_W | Stored configuration word |

## Verification
The pulse-width check assumes that fetch strobes never come on adjacent cycles. It also assumes that no vertical sync or line-load strobe shares a cycle with a fetch strobe. Those coincidences would legitimately re-arm and refire the request. The stimulus tasks drive one strobe at a time and follow each one with at least one idle cycle, so every pulse stays single-cycle and matches exactly one queued expectation. Mode changes go through the stop, reprogram and restart sequence. The exception is one deliberate write while running, which checks the mode lock.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;
  localparam int FRAME_MODE_BIT = 0;
  localparam int BUS_INV_BIT    = 1;
  localparam int AUTO_INV_BIT   = 2;
  localparam int RUN_BIT        = 3;
  localparam int FIELD_CNT      = 4;
  localparam int ARM_CNT        = 2;
  localparam int LINE_ARM       = 0;
  localparam int FRAME_ARM      = 1;

  typedef struct packed {
    logic run;
    logic auto_inv;
    logic bus_inv;
    logic frame_mode;
  } irq_cfg_t;
endpackage

// File: rtl/lcd_irq_regs.sv
module lcd_irq_regs
  import lcd_irq_pkg::*;
#(
  parameter int CFG_W = FIELD_CNT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output irq_cfg_t         cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.run        <= wr_data[RUN_BIT];
      cfg.auto_inv   <= wr_data[AUTO_INV_BIT];
      cfg.bus_inv    <= wr_data[BUS_INV_BIT];
      // mode is frozen while the scan engine is active
      cfg.frame_mode <= cfg.run ? cfg.frame_mode : wr_data[FRAME_MODE_BIT];
    end
  end

  // R7
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    cfg.run |=> $stable(cfg.frame_mode));

  // R1
  reset_cfg_chk: assert property (@(posedge clk)
    rst |=> (cfg == '0));
endmodule

// File: rtl/lcd_irq_arm.sv
module lcd_irq_arm #(
  parameter bit IDLE_VALUE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (!run)  flag_o <= IDLE_VALUE;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R4
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !set_i && clr_i) |=> !flag_o);

  // R6
  arm_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (flag_o == IDLE_VALUE));
endmodule

// File: rtl/lcd_irq_pulse.sv
module lcd_irq_pulse (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fetch,
  input  logic armed,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= run & fetch & armed;
  end

  // R6
  no_fire_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !irq_o);

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
endmodule

// File: rtl/lcd_irq_gen.sv
module lcd_irq_gen
  import lcd_irq_pkg::*;
#(
  parameter int CFG_W = FIELD_CNT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             vsync_i,
  input  logic             load_i,
  input  logic             fetch_start_i,
  output logic             irq_o,
  output logic             bus_inv_o,
  output logic             auto_inv_o,
  output logic [CFG_W-1:0] cfg_rdata
);
  irq_cfg_t           cfg;
  logic [ARM_CNT-1:0] arm_set;
  logic [ARM_CNT-1:0] arm_flag;
  logic               armed_sel;

  lcd_irq_regs #(.CFG_W(CFG_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg     (cfg)
  );

  assign arm_set[LINE_ARM]  = load_i;
  assign arm_set[FRAME_ARM] = vsync_i;

  // line arm idles armed so the first line after start fires;
  // frame arm idles disarmed so a restart waits for a fresh sync
  for (genvar g = 0; g < ARM_CNT; g++) begin : g_arm
    lcd_irq_arm #(.IDLE_VALUE(g == LINE_ARM)) u_arm (
      .clk    (clk),
      .rst    (rst),
      .run    (cfg.run),
      .set_i  (arm_set[g]),
      .clr_i  (fetch_start_i),
      .flag_o (arm_flag[g])
    );
  end

  assign armed_sel = cfg.frame_mode ? arm_flag[FRAME_ARM] : arm_flag[LINE_ARM];

  lcd_irq_pulse u_pulse (
    .clk   (clk),
    .rst   (rst),
    .run   (cfg.run),
    .fetch (fetch_start_i),
    .armed (armed_sel),
    .irq_o (irq_o)
  );

  assign bus_inv_o  = cfg.bus_inv;
  assign auto_inv_o = cfg.auto_inv;

  always_comb begin
    cfg_rdata                 = '0;
    cfg_rdata[FIELD_CNT-1:0]  = cfg;
  end

  // R1
  reset_irq_chk: assert property (@(posedge clk)
    rst |=> !irq_o);
endmodule

// File: tb/lcd_irq_gen_test.sv
module lcd_irq_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic vsync = 1'b0, load = 1'b0, fetch = 1'b0;
  logic irq, bus_inv, auto_inv;
  logic [CFG_W-1:0] rdata;

  lcd_irq_gen #(.CFG_W(CFG_W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .vsync_i(vsync), .load_i(load), .fetch_start_i(fetch),
    .irq_o(irq), .bus_inv_o(bus_inv), .auto_inv_o(auto_inv),
    .cfg_rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0, pulses = 0;
  int exp_q[$];
  bit prev_irq = 1'b0;
  bit done = 1'b0;

  // reference model state, from the requirements
  bit m_mode = 0, m_inv = 0, m_ainv = 0, m_run = 0;
  bit m_larm = 1, m_farm = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected pulse cycles
  always @(negedge clk) begin
    int e;
    if (!rst) begin
      if (irq && prev_irq) check(1'b0, "R5 pulse width", 2, 1);
      if (irq) begin
        pulses++;
        if (exp_q.size() == 0) check(1'b0, "R6 unexpected pulse", cyc, -1);
        else begin
          e = exp_q.pop_front();
          check(e == cyc, "R5 pulse cycle", cyc, e);
        end
      end
    end
    prev_irq = irq;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [CFG_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    if (!m_run) m_mode = d[0];
    m_inv = d[1]; m_ainv = d[2]; m_run = d[3];
    if (!m_run) begin m_larm = 1; m_farm = 0; end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_vsync();
    @(negedge clk);
    vsync = 1'b1;
    if (m_run) m_farm = 1;
    @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic do_load();
    @(negedge clk);
    load = 1'b1;
    if (m_run) m_larm = 1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_fetch();
    @(negedge clk);
    fetch = 1'b1;
    if (m_run) begin
      if (m_mode ? m_farm : m_larm) exp_q.push_back(cyc + 1);
      m_larm = 0; m_farm = 0;
    end
    @(negedge clk);
    fetch = 1'b0;
  endtask

  task automatic frame(input int lines);
    do_vsync();
    idle(1);
    for (int i = 0; i < lines; i++) begin
      do_fetch();
      idle(2);
      do_load();
      idle(1);
    end
  endtask

  task automatic check_regs(input string req);
    check(rdata == {m_run, m_ainv, m_inv, m_mode}, req, rdata, {m_run, m_ainv, m_inv, m_mode});
    check(bus_inv == m_inv, "R8 bus_inv", bus_inv, m_inv);
    check(auto_inv == m_ainv, "R8 auto_inv", auto_inv, m_ainv);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check(rdata == '0, "R1 cfg reset", rdata, 0);
    check(irq == 1'b0, "R1 irq reset", irq, 0);
    check_regs("R1 readback");

    // R2, R3: per-line mode
    do_write(4'b1000);
    check_regs("R2 run readback");
    p0 = pulses;
    repeat (3) frame(4);
    idle(3);
    check(pulses - p0 == 12, "R3 per-line count", pulses - p0, 12);

    // R3: repeated fetch without load fires once
    p0 = pulses;
    do_fetch(); idle(1); do_fetch(); idle(1); do_load(); idle(1); do_fetch();
    idle(3);
    check(pulses - p0 == 2, "R3 extra fetch ignored", pulses - p0, 2);

    // R7: mode accepted while stopped
    do_write(4'b0000);
    do_write(4'b0001);
    check_regs("R7 mode set while stopped");
    do_write(4'b1001);

    // R4: per-frame mode
    p0 = pulses;
    repeat (3) frame(4);
    idle(3);
    check(pulses - p0 == 3, "R4 per-frame count", pulses - p0, 3);

    // R7: mode write while running ignored
    do_write(4'b1000);
    check_regs("R7 mode locked while running");
    p0 = pulses;
    frame(3);
    idle(3);
    check(pulses - p0 == 1, "R7 still per-frame", pulses - p0, 1);

    // R6: stop discards pending first line, stopped fetch fires nothing
    p0 = pulses;
    do_vsync();
    do_write(4'b0001);
    do_fetch();
    do_write(4'b1001);
    do_fetch(); idle(1); do_load();
    idle(3);
    check(pulses - p0 == 0, "R6 no pulse after stop", pulses - p0, 0);

    // R8: polarity controls writable while running
    do_write(4'b1011);
    check_regs("R8 inversion while running");
    do_write(4'b1111);
    check_regs("R8 auto inversion while running");
    do_write(4'b0101);
    check_regs("R8 stopped fields");

    idle(4);
    check(exp_q.size() == 0, "R5 missing pulses", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule